// File: doc/BRIEF.md
# Byte/Word FIFO Packer with Watermark Requests

This block joins word-wide transmit and receive FIFOs to a protocol engine that moves one byte at a time. On the transmit side it pops a word from the TX FIFO and hands its bytes to the engine one by one, lowest byte lane first. It stops after a programmed number of bytes, so the unused upper lanes of the last word are dropped. On the receive side it gathers bytes from the engine into words in the same lane order. It pushes each word as soon as it is full, and it flushes the final word early, with its unused upper lanes cleared, when the programmed receive length is reached.

Two watermark comparators watch the FIFO occupancy. The transmit request asks the data mover for more words while TX occupancy is at or below a programmed level. A level of zero turns this request off. The receive request asks for words to be drained once RX occupancy reaches its level, and it is also forced high once the last word of a receive transfer has been pushed. That way a short tail below the watermark still gets collected. The RX word count is exposed so the reader knows how many words to take. The FIFO storage lives outside the block.

Top module: `byte_word_packer`

## Requirements
- R1: On transmit, byte lane k of a word (bits 8k+7:8k) is offered to the engine before lane k+1, so bits 7:0 go out first.
- R2: A transmit transfer of length L bytes offers exactly L bytes and pops exactly ceil(L/4) words. `eng_tx_last` is high together with the final byte only. Lanes past L in the final word are never offered, and after the final byte nothing further is offered or popped until the next `tx_start`. A length of zero pops nothing.
- R3: When the TX FIFO is empty during a transfer, no error is raised. `eng_tx_valid` stays low until a word is available, then the transfer resumes with the correct bytes.
- R4: A byte that is offered but not accepted stays offered, with the same value, on the next cycle. A word is never popped while the current one still has bytes to offer.
- R5: On receive, the first byte of each group of four lands in bits 7:0 and the fourth byte in bits 31:24. A full word is pushed as a one-cycle `rx_word_push` in the cycle after its fourth byte is accepted.
- R6: When the receive length is not a multiple of four, the final word is pushed in the cycle after the last byte arrives, with its unused upper lanes set to zero.
- R7: `rx_last` rises in the same cycle as the push of the final word of a receive transfer, even a partial one. It stays high until the next `rx_start`, and `rx_req` is high while it is set.
- R8: Receive bytes that arrive after the programmed length has been reached are ignored and cause no push.
- R9: `tx_wm_req` is high one cycle after `tx_fifo_level` <= `tx_wm_level` with a nonzero level, and it drops one cycle after occupancy rises above the level.
- R10: A `tx_wm_level` of zero keeps `tx_wm_req` low for every occupancy.
- R11: With a nonzero `rx_wm_level`, `rx_req` is high one cycle after `rx_fifo_level` >= `rx_wm_level` and follows the occupancy back down. `rx_word_count` always equals `rx_fifo_level`.
- R12: After reset, `tx_word_pop`, `eng_tx_valid`, `rx_word_push`, `rx_last`, `tx_wm_req` and `rx_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Pulse: begin a transmit transfer of `tx_len` bytes |
| tx_len | input | LEN_W | Transmit length in bytes |
| tx_word_valid | input | 1 | TX FIFO holds at least one word |
| tx_word_data | input | 8*WORD_BYTES | Head word of the TX FIFO |
| tx_word_pop | output | 1 | Take the head word of the TX FIFO |
| tx_fifo_level | input | LVL_W | TX FIFO occupancy in words |
| tx_wm_level | input | LVL_W | TX watermark; zero disables the request |
| tx_wm_req | output | 1 | TX refill request |
| eng_tx_valid | output | 1 | A transmit byte is offered |
| eng_tx_ready | input | 1 | Engine accepts the offered byte |
| eng_tx_data | output | 8 | Offered transmit byte |
| eng_tx_last | output | 1 | Offered byte is the last of the transfer |
| rx_start | input | 1 | Pulse: begin a receive transfer of `rx_len` bytes |
| rx_len | input | LEN_W | Receive length in bytes |
| eng_rx_valid | input | 1 | Engine delivers a byte |
| eng_rx_data | input | 8 | Delivered receive byte |
| rx_word_push | output | 1 | Write `rx_word_data` into the RX FIFO |
| rx_word_data | output | 8*WORD_BYTES | Packed receive word |
| rx_fifo_level | input | LVL_W | RX FIFO occupancy in words |
| rx_wm_level | input | LVL_W | RX watermark; zero disables the level request |
| rx_word_count | output | LVL_W | Readable RX words |
| rx_last | output | 1 | Final word of the receive transfer was pushed |
| rx_req | output | 1 | RX drain request (watermark or last word) |

## Verification
The bench builds the block with four bytes per word, an 8-bit length field and 6-bit occupancy fields. A 32-deep FIFO therefore has every occupancy value from empty to full within reach, including a watermark at depth minus one and occupancy one above it. Transfer lengths run from zero to a few dozen bytes with random engine back-pressure and random FIFO gaps. This covers every position of the final partial word, stalls that fall inside and between words, and surplus receive bytes past the programmed length.

// File: rtl/packer_pkg.sv
package packer_pkg;
    localparam int BYTE_W = 8;

    // Direction of a watermark comparison
    typedef enum logic {
        WM_AT_OR_BELOW = 1'b0,
        WM_AT_OR_ABOVE = 1'b1
    } wm_dir_e;
endpackage

// File: rtl/tx_unpacker.sv
module tx_unpacker #(
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = 16,
    localparam int DW        = packer_pkg::BYTE_W * WORD_BYTES,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             word_valid,
    input  logic [DW-1:0]    word_data,
    output logic             word_pop,
    output logic             byte_valid,
    input  logic             byte_ready,
    output logic [7:0]       byte_data,
    output logic             byte_last
);
    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [IDX_W-1:0] lane;
        logic             full;
        logic [DW-1:0]    word;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      pop_d;

    always_comb begin
        st_d  = st_q;
        pop_d = 1'b0;
        if (start) begin
            st_d.rem  = len;
            st_d.lane = '0;
            st_d.full = 1'b0;
        end else begin
            // hand one byte to the engine
            if (st_q.full && byte_ready) begin
                st_d.rem  = st_q.rem - 1'b1;
                st_d.lane = st_q.lane + 1'b1;
                if (st_q.lane == IDX_W'(WORD_BYTES - 1) || st_q.rem == LEN_W'(1)) begin
                    st_d.full = 1'b0;
                    st_d.lane = '0;
                end
            end
            // refill only once the held word is spent; stall on an empty FIFO
            if (!st_q.full && st_q.rem != '0 && word_valid) begin
                pop_d     = 1'b1;
                st_d.word = word_data;
                st_d.full = 1'b1;
                st_d.lane = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_pop   = pop_d;
    assign byte_valid = st_q.full;
    assign byte_data  = st_q.word[st_q.lane*8 +: 8];
    assign byte_last  = st_q.full && (st_q.rem == LEN_W'(1));

    // R4: an offered byte that is not taken is held unchanged
    p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready && !start) |=> (byte_valid && $stable(byte_data)));

    // R4: no pop while bytes remain in the held word
    p_no_pop_while_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !word_pop);

    // R2: nothing is offered after the final byte is accepted
    p_quiet_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_last && byte_ready && !start) |=> !byte_valid);
endmodule

// File: rtl/rx_packer.sv
module rx_packer #(
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = 16,
    localparam int DW        = packer_pkg::BYTE_W * WORD_BYTES,
    localparam int IDX_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    output logic             word_push,
    output logic [DW-1:0]    word_data,
    output logic             last
);
    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [IDX_W-1:0] lane;
        logic [DW-1:0]    acc;
        logic             push;
        logic [DW-1:0]    out;
        logic             last;
    } rx_state_t;

    rx_state_t     st_d, st_q;
    logic [DW-1:0] acc_n;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        acc_n     = st_q.acc;
        if (start) begin
            st_d.rem  = len;
            st_d.lane = '0;
            st_d.acc  = '0;
            st_d.last = 1'b0;
        end else if (byte_valid && st_q.rem != '0) begin
            acc_n[st_q.lane*8 +: 8] = byte_data;
            st_d.rem = st_q.rem - 1'b1;
            if (st_q.lane == IDX_W'(WORD_BYTES - 1) || st_q.rem == LEN_W'(1)) begin
                // word complete or transfer length reached: flush
                st_d.push = 1'b1;
                st_d.out  = acc_n;
                st_d.acc  = '0;
                st_d.lane = '0;
                st_d.last = (st_q.rem == LEN_W'(1));
            end else begin
                st_d.acc  = acc_n;
                st_d.lane = st_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_push = st_q.push;
    assign word_data = st_q.out;
    assign last      = st_q.last;

    // R8: once the length is used up, bytes produce no push
    p_idle_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rem == '0 && !start) |=> !word_push);

    // R7: the last flag is held until a new transfer starts
    p_last_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> last);

    // R7: the last flag rises together with a push
    p_last_with_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(last) |-> word_push);
endmodule

// File: rtl/wm_compare.sv
module wm_compare #(
    parameter int                  LVL_W = 6,
    parameter packer_pkg::wm_dir_e DIR   = packer_pkg::WM_AT_OR_BELOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mark,
    output logic             req
);
    logic hit;
    logic req_d, req_q;

    generate
        if (DIR == packer_pkg::WM_AT_OR_BELOW) begin : g_below
            assign hit = (level <= mark);
        end else begin : g_above
            assign hit = (level >= mark);
        end
    endgenerate

    always_comb begin
        req_d = (mark != '0) && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign req = req_q;

    // R10: a zero mark keeps the request off
    p_zero_mark_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mark == '0) |=> !req);
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
    parameter int WORD_BYTES = 4,
    parameter int LEN_W      = 16,
    parameter int LVL_W      = 6,
    localparam int DW        = packer_pkg::BYTE_W * WORD_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_word_valid,
    input  logic [DW-1:0]    tx_word_data,
    output logic             tx_word_pop,
    input  logic [LVL_W-1:0] tx_fifo_level,
    input  logic [LVL_W-1:0] tx_wm_level,
    output logic             tx_wm_req,
    output logic             eng_tx_valid,
    input  logic             eng_tx_ready,
    output logic [7:0]       eng_tx_data,
    output logic             eng_tx_last,
    input  logic             rx_start,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             eng_rx_valid,
    input  logic [7:0]       eng_rx_data,
    output logic             rx_word_push,
    output logic [DW-1:0]    rx_word_data,
    input  logic [LVL_W-1:0] rx_fifo_level,
    input  logic [LVL_W-1:0] rx_wm_level,
    output logic [LVL_W-1:0] rx_word_count,
    output logic             rx_last,
    output logic             rx_req
);
    logic rx_wm_hit;

    tx_unpacker #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .len        (tx_len),
        .word_valid (tx_word_valid),
        .word_data  (tx_word_data),
        .word_pop   (tx_word_pop),
        .byte_valid (eng_tx_valid),
        .byte_ready (eng_tx_ready),
        .byte_data  (eng_tx_data),
        .byte_last  (eng_tx_last)
    );

    rx_packer #(.WORD_BYTES(WORD_BYTES), .LEN_W(LEN_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rx_start),
        .len        (rx_len),
        .byte_valid (eng_rx_valid),
        .byte_data  (eng_rx_data),
        .word_push  (rx_word_push),
        .word_data  (rx_word_data),
        .last       (rx_last)
    );

    wm_compare #(.LVL_W(LVL_W), .DIR(packer_pkg::WM_AT_OR_BELOW)) u_tx_wm (
        .clk   (clk),
        .rst_n (rst_n),
        .level (tx_fifo_level),
        .mark  (tx_wm_level),
        .req   (tx_wm_req)
    );

    wm_compare #(.LVL_W(LVL_W), .DIR(packer_pkg::WM_AT_OR_ABOVE)) u_rx_wm (
        .clk   (clk),
        .rst_n (rst_n),
        .level (rx_fifo_level),
        .mark  (rx_wm_level),
        .req   (rx_wm_hit)
    );

    assign rx_req        = rx_wm_hit | rx_last;
    assign rx_word_count = rx_fifo_level;

    // R9: a nonzero mark with occupancy above it yields no TX request
    p_tx_wm_above_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wm_level != '0 && tx_fifo_level > tx_wm_level) |=> !tx_wm_req);
endmodule

// File: tb/byte_word_packer_bench.sv
module byte_word_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WB    = 4;
    localparam int LEN_W = 8;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_start = 1'b0;
    logic [LEN_W-1:0] tx_len = '0;
    logic             tx_word_valid = 1'b0;
    logic [31:0]      tx_word_data = '0;
    logic             tx_word_pop;
    logic [LVL_W-1:0] tx_fifo_level = '0;
    logic [LVL_W-1:0] tx_wm_level = '0;
    logic             tx_wm_req;
    logic             eng_tx_valid;
    logic             eng_tx_ready = 1'b0;
    logic [7:0]       eng_tx_data;
    logic             eng_tx_last;
    logic             rx_start = 1'b0;
    logic [LEN_W-1:0] rx_len = '0;
    logic             eng_rx_valid = 1'b0;
    logic [7:0]       eng_rx_data = '0;
    logic             rx_word_push;
    logic [31:0]      rx_word_data;
    logic [LVL_W-1:0] rx_fifo_level = '0;
    logic [LVL_W-1:0] rx_wm_level = '0;
    logic [LVL_W-1:0] rx_word_count;
    logic             rx_last;
    logic             rx_req;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_word_packer #(.WORD_BYTES(WB), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_byte_word_packer (
        .clk, .rst_n, .tx_start, .tx_len, .tx_word_valid, .tx_word_data, .tx_word_pop,
        .tx_fifo_level, .tx_wm_level, .tx_wm_req, .eng_tx_valid, .eng_tx_ready,
        .eng_tx_data, .eng_tx_last, .rx_start, .rx_len, .eng_rx_valid, .eng_rx_data,
        .rx_word_push, .rx_word_data, .rx_fifo_level, .rx_wm_level, .rx_word_count,
        .rx_last, .rx_req
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected lane value of a byte stream position
    function automatic logic [7:0] lane_of(input logic [31:0] w, input int k);
        return w[k*8 +: 8];
    endfunction

    // expected packed receive word: lanes past the length are zero
    function automatic logic [31:0] pack_word(input logic [7:0] b[$], input int w, input int len);
        logic [31:0] r = '0;
        for (int k = 0; k < WB; k++)
            if (w*WB + k < len) r[k*8 +: 8] = b[w*WB + k];
        return r;
    endfunction

    task automatic run_tx(input int len, input int stall);
        logic [31:0] words[$];
        logic [31:0] q[$];
        int nw = (len + WB - 1) / WB;
        int sent = 0, pops = 0, cyc = 0, first_pop = -1;
        int byte_bad = 0, last_bad = 0, hold_bad = 0, extra = 0;
        bit hold_pend = 0, in_stall;
        logic [7:0] hold_val = '0;
        logic [7:0] exp_b;
        for (int i = 0; i < nw; i++) words.push_back($urandom());
        q = words;
        tx_len = LEN_W'(len);
        tx_start = 1'b1;
        @(posedge clk); #1;
        tx_start = 1'b0;
        while (sent < len && cyc < 400) begin
            in_stall = (stall > 0) && (first_pop >= 0) && (cyc - first_pop >= 1) && (cyc - first_pop <= stall);
            tx_word_valid = (q.size() > 0) && !in_stall && ((stall > 0) || ($urandom_range(0, 3) != 0));
            tx_word_data  = (q.size() > 0) ? q[0] : 32'hDEAD_BEEF;
            eng_tx_ready  = (stall > 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
            #1;
            if (stall > 0 && first_pop >= 0 && cyc - first_pop == stall)
                chk(eng_tx_valid == 1'b0 && tx_word_pop == 1'b0, "R3 no byte offered while FIFO empty",
                    32'(eng_tx_valid), 32'd0);
            if (hold_pend && (!eng_tx_valid || eng_tx_data != hold_val)) hold_bad++;
            if (tx_word_pop && eng_tx_valid) hold_bad++;
            hold_pend = eng_tx_valid && !eng_tx_ready;
            hold_val  = eng_tx_data;
            if (eng_tx_valid && eng_tx_ready) begin
                exp_b = lane_of(words[sent / WB], sent % WB);
                if (eng_tx_data != exp_b) byte_bad++;
                if (eng_tx_last != (sent == len - 1)) last_bad++;
                sent++;
            end
            if (tx_word_pop) begin
                if (q.size() > 0) void'(q.pop_front());
                pops++;
                if (first_pop < 0) first_pop = cyc;
            end
            @(posedge clk); #1;
            cyc++;
        end
        // present a word after the end: nothing may be taken or offered
        tx_word_valid = 1'b1;
        tx_word_data  = 32'h1234_5678;
        eng_tx_ready  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            if (eng_tx_valid || tx_word_pop) extra++;
            @(posedge clk); #1;
        end
        tx_word_valid = 1'b0;
        chk(byte_bad == 0, "R1 transmit lane order", 32'(byte_bad), 32'd0);
        chk(sent == len, "R2 transmit byte count", 32'(sent), 32'(len));
        chk(pops == nw, "R2 transmit word pops", 32'(pops), 32'(nw));
        chk(last_bad == 0 && extra == 0, "R2 last flag and quiet end", 32'(last_bad + extra), 32'd0);
        chk(hold_bad == 0, "R4 held byte under back-pressure", 32'(hold_bad), 32'd0);
    endtask

    task automatic run_rx(input int len, input int surplus);
        logic [7:0]  b[$];
        logic [31:0] got[$];
        int nw = (len + WB - 1) / WB;
        int i = 0, bad_full = 0, bad_part = 0, last_bad = 0;
        bit v;
        for (int k = 0; k < len + surplus; k++) b.push_back(8'($urandom()));
        rx_len = LEN_W'(len);
        rx_start = 1'b1;
        @(posedge clk); #1;
        rx_start = 1'b0;
        chk(rx_last == 1'b0, "R7 last cleared by start", 32'(rx_last), 32'd0);
        while (i < len + surplus) begin
            v = ($urandom_range(0, 2) != 0);
            eng_rx_valid = v;
            eng_rx_data  = b[i];
            @(posedge clk); #1;
            if (v) i++;
            if (rx_word_push) begin
                got.push_back(rx_word_data);
                // last must rise exactly with the final push
                if (rx_last != (got.size() == nw)) last_bad++;
            end else if (rx_last && got.size() < nw) last_bad++;
        end
        eng_rx_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            if (rx_word_push) got.push_back(rx_word_data);
        end
        chk(got.size() == nw, "R8 push count with surplus bytes", 32'(got.size()), 32'(nw));
        for (int w = 0; w < nw && w < got.size(); w++) begin
            if (got[w] != pack_word(b, w, len)) begin
                if ((w + 1) * WB <= len) bad_full++;
                else bad_part++;
            end
        end
        chk(bad_full == 0, "R5 full receive words", 32'(bad_full), 32'd0);
        chk(bad_part == 0, "R6 partial final word zero-filled", 32'(bad_part), 32'd0);
        if (len > 0) begin
            chk(last_bad == 0 && rx_last == 1'b1, "R7 last with final push", 32'(rx_last), 32'd1);
            chk(rx_req == 1'b1, "R7 request while last held", 32'(rx_req), 32'd1);
        end
    endtask

    task automatic wm_case(input int tl, input int tw, input int rl, input int rw);
        bit exp_t, exp_r;
        tx_fifo_level = LVL_W'(tl);
        tx_wm_level   = LVL_W'(tw);
        rx_fifo_level = LVL_W'(rl);
        rx_wm_level   = LVL_W'(rw);
        @(posedge clk); #1;
        exp_t = (tw != 0) && (tl <= tw);
        exp_r = ((rw != 0) && (rl >= rw)) || rx_last;
        if (tw == 0) chk(tx_wm_req == 1'b0, "R10 zero TX mark disables", 32'(tx_wm_req), 32'd0);
        else chk(tx_wm_req == exp_t, "R9 TX watermark request", 32'(tx_wm_req), 32'(exp_t));
        chk(rx_req == exp_r, "R11 RX watermark request", 32'(rx_req), 32'(exp_r));
        chk(rx_word_count == LVL_W'(rl), "R11 RX word count", 32'(rx_word_count), 32'(rl));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk(tx_word_pop == 0 && eng_tx_valid == 0 && rx_word_push == 0, "R12 datapath idle in reset",
            32'({tx_word_pop, eng_tx_valid, rx_word_push}), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(rx_last == 0 && tx_wm_req == 0 && rx_req == 0, "R12 requests low after reset",
            32'({rx_last, tx_wm_req, rx_req}), 32'd0);

        // directed transmit corners
        run_tx(1, 0);
        run_tx(4, 0);
        run_tx(7, 0);
        run_tx(0, 0);
        run_tx(10, 8);   // R3: FIFO runs dry after the first word
        run_tx(6, 9);    // R3: stall before a partial tail
        for (int n = 0; n < 12; n++) run_tx($urandom_range(1, 40), 0);

        // directed receive corners
        run_rx(4, 0);
        run_rx(1, 3);
        run_rx(6, 5);
        run_rx(3, 2);
        for (int n = 0; n < 12; n++) run_rx($urandom_range(1, 40), $urandom_range(0, 6));

        // watermarks: clear the sticky last flag first
        rx_len = '0;
        rx_start = 1'b1;
        @(posedge clk); #1;
        rx_start = 1'b0;
        wm_case(31, 31, 8, 8);   // at the mark, depth minus one
        wm_case(32, 31, 7, 8);   // one above / one below
        wm_case(0, 0, 0, 0);     // zero marks
        wm_case(32, 0, 32, 0);
        wm_case(5, 12, 32, 1);
        wm_case(13, 12, 0, 1);
        for (int n = 0; n < 20; n++)
            wm_case($urandom_range(0, 32), $urandom_range(0, 32), $urandom_range(0, 32), $urandom_range(0, 32));

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule